// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one active-low external interrupt pin and turns activity on it into a latched interrupt request for a small processor. The pin is resynchronized, a falling edge is detected, and the result is held in a request latch. The latch is readable as a pending flag. It is cleared either by the processor's vector-fetch acknowledge or by software writing an acknowledge bit.

A four-bit control/status register holds three things: a trigger-mode selector, a request mask, and the pending flag. Edge mode lets any acknowledge clear the request. Level mode refuses to clear the request while the pin is still held low. A masked request stays visible to polling software but does not reach the processor. An unmasked request also raises a wakeup request for wait and stop modes. While a debug break is active, acknowledges leave the status untouched unless a break-clear-enable input allows the clear.

Top module: `extint_ctrl`

## Requirements
- R1: After reset with the pin high, the pending flag, mode and mask read 0 and `irqReq`/`wakeReq` are low. No request appears while the pin stays high.
- R2: A falling edge on `pinAsync` sets the pending flag on the third rising clock edge after the pin goes low. A pin that stays low after the request is cleared does not set it again.
- R3: In edge mode (mode bit 0), a `vecAck` pulse, or a register write with bit 0 (acknowledge) set, clears the pending flag at that clock edge when break protection does not apply.
- R4: The pending flag reads back whatever the mask is. While the mask bit is 1, `irqReq` is low. While the mask bit is 0, `irqReq` equals the pending flag.
- R5: `wakeReq` is high exactly when a pending request is unmasked.
- R6: In level mode (mode bit 1), an acknowledge is ignored while the synchronized pin is low. After the pin has returned high and passed the synchronizer, an acknowledge clears the flag.
- R7: While `brkActive` is 1 and `brkClrEn` is 0, acknowledges do not clear the pending flag. Register writes to mode and mask still take effect.
- R8: While `brkActive` is 1 and `brkClrEn` is 1, an acknowledge clears the flag, and the flag stays clear after the break ends.
- R9: If a new falling edge and a clearing acknowledge reach the latch in the same cycle, the latch ends up set.
- R10: When `regRd` is 1, `rdData` shows bit 3 = pending, bit 2 = mode, bit 1 = mask and bit 0 = 0. When `regRd` is 0, `rdData` is 0. A register write loads mode from bit 2 and mask from bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinAsync | input | 1 | Raw active-low interrupt pin |
| vecAck | input | 1 | Interrupt vector fetch acknowledge strobe |
| regWr | input | 1 | Control register write strobe |
| regRd | input | 1 | Control register read strobe |
| wrData | input | 4 | Write data (bit0 ack, bit1 mask, bit2 mode) |
| brkActive | input | 1 | Debug break state indicator |
| brkClrEn | input | 1 | Allows status clears during break |
| rdData | output | 4 | Register read data |
| irqReq | output | 1 | Interrupt request to the processor |
| wakeReq | output | 1 | Wakeup request for low-power modes |

## Verification
A falling edge can set the latch in the same cycle that an acknowledge tries to clear it. The bench provokes this by timing a `vecAck` pulse onto the exact clock edge at which the synchronized edge reaches the latch. It then expects the flag to survive. In level mode, the same collision between the pin state and an acknowledge is swept through random stimulus, including breaks, and compared each cycle against a bench model of the requirements.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int REG_W    = 4;
  localparam int ACK_BIT  = 0;
  localparam int MASK_BIT = 1;
  localparam int MODE_BIT = 2;
  localparam int PEND_BIT = 3;

  typedef struct packed {
    logic setReq;
    logic clrReq;
    logic wrCfg;
  } ctlStrb_t;
endpackage

// File: rtl/extint_ctl.sv
module extint_ctl
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinAsync,
  input  logic             vecAck,
  input  logic             regWr,
  input  logic [REG_W-1:0] wrData,
  input  logic             brkActive,
  input  logic             brkClrEn,
  input  logic             modeLvl,
  output ctlStrb_t         strb,
  output logic             pinHigh
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic prevPin;
  logic ackReq;
  logic clrAllowed;

  // resynchronizer, resets to the idle (high) pin level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '1;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinAsync};
  end

  assign pinHigh = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPin <= 1'b1;
    else       prevPin <= pinHigh;
  end

  assign ackReq     = vecAck | (regWr & wrData[ACK_BIT]);
  assign clrAllowed = ~brkActive | brkClrEn;

  always_comb begin
    strb.setReq = prevPin & ~pinHigh;
    strb.clrReq = ackReq & clrAllowed & (~modeLvl | pinHigh);
    strb.wrCfg  = regWr;
  end
endmodule

// File: rtl/extint_dp.sv
module extint_dp
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  logic [REG_W-1:0] wrData,
  input  logic             regRd,
  output logic             modeLvl,
  output logic             maskOn,
  output logic             pendFlag,
  output logic [REG_W-1:0] rdData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeLvl <= 1'b0;
      maskOn  <= 1'b0;
    end else if (strb.wrCfg) begin
      modeLvl <= wrData[MODE_BIT];
      maskOn  <= wrData[MASK_BIT];
    end
  end

  // a fresh edge wins over a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pendFlag <= 1'b0;
    else if (strb.setReq) pendFlag <= 1'b1;
    else if (strb.clrReq) pendFlag <= 1'b0;
  end

  always_comb begin
    rdData = '0;
    if (regRd) begin
      rdData[PEND_BIT] = pendFlag;
      rdData[MODE_BIT] = modeLvl;
      rdData[MASK_BIT] = maskOn;
    end
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinAsync,
  input  logic             vecAck,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [REG_W-1:0] wrData,
  input  logic             brkActive,
  input  logic             brkClrEn,
  output logic [REG_W-1:0] rdData,
  output logic             irqReq,
  output logic             wakeReq
);
  ctlStrb_t strb;
  logic modeLvl, maskOn, pendFlag, pinHigh;

  extint_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .pinAsync(pinAsync), .vecAck(vecAck),
    .regWr(regWr), .wrData(wrData), .brkActive(brkActive),
    .brkClrEn(brkClrEn), .modeLvl(modeLvl), .strb(strb), .pinHigh(pinHigh)
  );

  extint_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .regRd(regRd),
    .modeLvl(modeLvl), .maskOn(maskOn), .pendFlag(pendFlag), .rdData(rdData)
  );

  assign irqReq  = pendFlag & ~maskOn;
  assign wakeReq = pendFlag & ~maskOn;
endmodule

// File: rtl/extint_chk.sv
module extint_chk (
  input logic clk,
  input logic rstN,
  input logic irqReq,
  input logic wakeReq,
  input logic pending,
  input logic modeLvl,
  input logic maskOn,
  input logic setReq,
  input logic vecAck,
  input logic brkActive,
  input logic brkClrEn,
  input logic pinNow
);
  assert_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    setReq |=> pending);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!modeLvl && vecAck && !setReq && (!brkActive || brkClrEn)) |=> !pending);

  assert_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    maskOn |-> !irqReq);

  assert_wake_R5: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (pending && !maskOn));

  assert_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeLvl && pending && !pinNow) |=> pending);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (brkActive && !brkClrEn && pending) |=> pending);
endmodule

bind extint_ctrl extint_chk u_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .wakeReq(wakeReq),
  .pending(pendFlag), .modeLvl(modeLvl), .maskOn(maskOn),
  .setReq(strb.setReq), .vecAck(vecAck), .brkActive(brkActive),
  .brkClrEn(brkClrEn), .pinNow(pinHigh)
);

// File: tb/sim_extint_ctrl.sv
`timescale 1ns/1ps
module sim_extint_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinAsync = 1'b1, vecAck = 1'b0, regWr = 1'b0, regRd = 1'b1;
  logic [3:0] wrData = 4'h0;
  logic brkActive = 1'b0, brkClrEn = 1'b0;
  logic [3:0] rdData;
  logic irqReq, wakeReq;

  int checks = 0;
  int errors = 0;

  // model state
  logic m1 = 1'b1, m2 = 1'b1, mPrev = 1'b1, mMode = 1'b0, mMask = 1'b0, mPend = 1'b0;

  always #4 clk = ~clk;

  extint_ctrl u0 (
    .clk(clk), .rstN(rstN), .pinAsync(pinAsync), .vecAck(vecAck),
    .regWr(regWr), .regRd(regRd), .wrData(wrData), .brkActive(brkActive),
    .brkClrEn(brkClrEn), .rdData(rdData), .irqReq(irqReq), .wakeReq(wakeReq)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expRd();
    return regRd ? {mPend, mMode, mMask, 1'b0} : 4'h0;
  endfunction

  // one clock: advance model on the edge, compare just after
  task automatic step(input string tag);
    logic fall, ack, clr, nPend;
    @(posedge clk);
    fall  = mPrev & ~m2;
    ack   = vecAck | (regWr & wrData[0]);
    clr   = ack & (~brkActive | brkClrEn) & (~mMode | m2);
    nPend = fall ? 1'b1 : (clr ? 1'b0 : mPend);
    if (regWr) begin mMode = wrData[2]; mMask = wrData[1]; end
    mPrev = m2; m2 = m1; m1 = pinAsync; mPend = nPend;
    #1;
    chk({tag, " rdData"}, rdData, expRd());
    chk({tag, " irqReq"}, {3'b0, irqReq}, {3'b0, mPend & ~mMask});
    chk({tag, " wakeReq"}, {3'b0, wakeReq}, {3'b0, mPend & ~mMask});
  endtask

  task automatic idle();
    vecAck = 1'b0; regWr = 1'b0; wrData = 4'h0;
  endtask

  task automatic cfgWrite(input logic [3:0] d, input string tag);
    regWr = 1'b1; wrData = d; step(tag); idle();
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #21 rstN = 1'b1;
    // R1 reset state
    #1 chk("R1 reset read", rdData, 4'h0);
    repeat (4) step("R1");
    // R2 falling edge sets on the third edge
    pinAsync = 1'b0;
    step("R2"); step("R2");
    chk("R2 not yet", rdData, 4'h0);
    step("R2");
    chk("R2 pending", rdData, 4'h8);
    // R3 software acknowledge in edge mode
    cfgWrite(4'h1, "R3 ackwrite");
    chk("R3 cleared", rdData, 4'h0);
    repeat (4) step("R2 low no reset");
    pinAsync = 1'b1; repeat (3) step("R2");
    // R4 masked edge
    cfgWrite(4'h2, "R4 mask");
    pinAsync = 1'b0; repeat (3) step("R4");
    chk("R4 masked pending", rdData, 4'hA);
    chk("R4 irq low", {3'b0, irqReq}, 4'h0);
    cfgWrite(4'h0, "R4 unmask");
    chk("R5 wake", {3'b0, wakeReq}, 4'h1);
    // R7 break protection
    brkActive = 1'b1; vecAck = 1'b1; step("R7"); idle();
    chk("R7 held", rdData, 4'h8);
    cfgWrite(4'h3, "R7 ack+mask write");
    chk("R7 cfg took", rdData, 4'hA);
    // R8 break clear enable
    brkClrEn = 1'b1; vecAck = 1'b1; step("R8"); idle();
    chk("R8 cleared", rdData, 4'h2);
    brkActive = 1'b0; brkClrEn = 1'b0; repeat (2) step("R8");
    chk("R8 stays clear", rdData, 4'h2);
    cfgWrite(4'h0, "R10 unmask");
    pinAsync = 1'b1; repeat (3) step("R6");
    // R6 level mode
    cfgWrite(4'h4, "R6 mode");
    pinAsync = 1'b0; repeat (3) step("R6");
    vecAck = 1'b1; step("R6 ack low"); idle();
    chk("R6 held", rdData, 4'hC);
    pinAsync = 1'b1; repeat (2) step("R6");
    vecAck = 1'b1; step("R6 ack high"); idle();
    chk("R6 cleared", rdData, 4'h4);
    // R9 set and clear together
    cfgWrite(4'h0, "R9 edge mode");
    pinAsync = 1'b0; step("R9"); step("R9");
    vecAck = 1'b1; step("R9 collide"); idle();
    chk("R9 set wins", rdData, 4'h8);
    // R10 read strobe off
    regRd = 1'b0; step("R10");
    chk("R10 rd gated", rdData, 4'h0);
    regRd = 1'b1;
    // random mix
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) pinAsync = ~pinAsync;
      vecAck    = ($urandom_range(0, 7) == 0);
      regWr     = ($urandom_range(0, 9) == 0);
      wrData    = 4'($urandom_range(0, 15));
      regRd     = ($urandom_range(0, 3) != 0);
      brkActive = ($urandom_range(0, 4) == 0);
      brkClrEn  = ($urandom_range(0, 1) == 0);
      step("R9 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule